// File: doc/BRIEF.md
# Tagged Load Buffer

This block is a small pool of load slots for an out-of-order floating-point core. Each slot acts as a tagged producer of results. When the issue stage hands over a load, the lowest free slot takes the base value and the offset. One cycle later it adds them to form the effective address. It then asks the memory port for that address and keeps the request marked outstanding until memory answers.

Memory answers carry the tag of the slot that asked, so answers may come back in any order. A slot that holds returned data asks for the shared result broadcast bus. When the bus is granted, the slot drives its data together with its own tag and becomes free again. Several loads can be waiting on memory at once. Issue stalls while every slot is busy.

Top module: `load_buffer`

## Requirements
- R1: During and right after reset, `iss_ready` is 1, and `mem_req_valid` and `bus_req` are 0.
- R2: An issue (`iss_valid` and `iss_ready` high at a clock edge) is taken by the free slot with the lowest index. Slot i owns tag TAG_BASE+i, so slots 0, 1 and 2 own tags 6, 7 and 8.
- R3: A load issued at edge k presents its memory request from edge k+2 onward. The request address is `iss_base + iss_offset`, modulo 2^AW, and the request carries the slot's tag. `mem_req_valid` stays 0 between edge k and edge k+1.
- R4: Once `mem_req_valid` is high, it stays high until an edge at which `mem_req_ready` is high.
- R5: While several slots wait to send, the slot with the lowest index is offered first. Each slot's request leaves exactly once. Up to three loads may be outstanding together.
- R6: A response (`mem_rsp_valid`) is taken only by the slot whose tag equals `mem_rsp_tag` and whose request is outstanding. Responses may come in any order. Responses with any other tag, and repeated responses to a slot that already holds data, change nothing.
- R7: `bus_req` is high while any slot holds data. `bus_tag` and `bus_data` come from the lowest-index slot holding data, and `bus_req` stays high until a grant.
- R8: A slot whose data is broadcast under `bus_grant` becomes free. `iss_ready` is 1 whenever at least one slot is free.
- R9: With all slots busy, `iss_ready` is 0 and an issue attempt has no effect: no extra memory request or broadcast appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue stage offers a load |
| iss_base | input | AW | Base register value |
| iss_offset | input | AW | Address offset |
| iss_ready | output | 1 | A slot is free to take a load |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Effective address |
| mem_req_tag | output | TAG_W | Tag of the requesting slot |
| mem_rsp_valid | input | 1 | Memory returns data |
| mem_rsp_tag | input | TAG_W | Tag the data belongs to |
| mem_rsp_data | input | DW | Returned data |
| bus_req | output | 1 | Request for the broadcast bus |
| bus_grant | input | 1 | Broadcast slot granted |
| bus_tag | output | TAG_W | Producer tag on the bus |
| bus_data | output | DW | Load result on the bus |

## Verification
The bench builds the block with three slots, tags starting at 6, a 16-bit address and 32-bit data. With a 16-bit address, random base and offset pairs often wrap past 2^16, which exercises the modulo sum. With only three slots, random back-pressure from memory and from the bus fills the pool often, so the issue stall is exercised many times. Out-of-order responses, responses carrying unrelated tags and several slots holding data at once are all reached within a few thousand cycles.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [2:0] {
    LB_FREE = 3'd0,
    LB_AGEN = 3'd1,
    LB_SEND = 3'd2,
    LB_WAIT = 3'd3,
    LB_HOLD = 3'd4
  } lb_state_e;
endpackage

// File: rtl/lb_pick.sv
// Fixed-priority picker: grants the lowest set bit of req.
module lb_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb_entry.sv
// One load slot: captures operands, forms the address, sends, waits, holds.
module lb_entry
  import lb_pkg::*;
#(
  parameter int              AW     = 32,
  parameter int              DW     = 32,
  parameter int              TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   offset,
  input  logic            req_win,
  input  logic            rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic [DW-1:0]   rsp_data,
  input  logic            bcast_done,
  output lb_state_e       state_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o
);
  lb_state_e     state_q;
  logic [AW-1:0] base_q, off_q, addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LB_FREE;
      base_q  <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        LB_FREE: if (alloc) begin
          base_q  <= base;
          off_q   <= offset;
          state_q <= LB_AGEN;
        end
        LB_AGEN: begin
          addr_q  <= base_q + off_q;
          state_q <= LB_SEND;
        end
        LB_SEND: if (req_win) state_q <= LB_WAIT;
        LB_WAIT: if (rsp_valid && (rsp_tag == MY_TAG)) begin
          data_q  <= rsp_data;
          state_q <= LB_HOLD;
        end
        LB_HOLD: if (bcast_done) state_q <= LB_FREE;
        default: state_q <= LB_FREE;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/load_buffer.sv
module load_buffer
  import lb_pkg::*;
#(
  parameter int N_ENTRIES = 3,
  parameter int TAG_BASE  = 6,
  parameter int TAG_W     = 4,
  parameter int AW        = 32,
  parameter int DW        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [AW-1:0]    iss_base,
  input  logic [AW-1:0]    iss_offset,
  output logic             iss_ready,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic [TAG_W-1:0] mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [TAG_W-1:0] mem_rsp_tag,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             bus_req,
  input  logic             bus_grant,
  output logic [TAG_W-1:0] bus_tag,
  output logic [DW-1:0]    bus_data
);
  localparam int N = N_ENTRIES;

  lb_state_e     ent_state [N];
  logic [AW-1:0] ent_addr  [N];
  logic [DW-1:0] ent_data  [N];

  logic [N-1:0] free_v, send_v, hold_v;
  logic [N-1:0] free_g, send_g, hold_g;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      free_v[i] = (ent_state[i] == LB_FREE);
      send_v[i] = (ent_state[i] == LB_SEND);
      hold_v[i] = (ent_state[i] == LB_HOLD);
    end
  end

  lb_pick #(.N(N)) u_pick_free (.req(free_v), .gnt(free_g));
  lb_pick #(.N(N)) u_pick_send (.req(send_v), .gnt(send_g));
  lb_pick #(.N(N)) u_pick_hold (.req(hold_v), .gnt(hold_g));

  for (genvar g = 0; g < N; g++) begin : g_ent
    lb_entry #(
      .AW(AW), .DW(DW), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(TAG_BASE + g))
    ) u_ent (
      .clk       (clk),
      .rst       (rst),
      .alloc     (free_g[g] & iss_valid),
      .base      (iss_base),
      .offset    (iss_offset),
      .req_win   (send_g[g] & mem_req_ready),
      .rsp_valid (mem_rsp_valid),
      .rsp_tag   (mem_rsp_tag),
      .rsp_data  (mem_rsp_data),
      .bcast_done(hold_g[g] & bus_grant),
      .state_o   (ent_state[g]),
      .addr_o    (ent_addr[g]),
      .data_o    (ent_data[g])
    );
  end

  assign iss_ready     = |free_v;
  assign mem_req_valid = |send_v;
  assign bus_req       = |hold_v;

  always_comb begin
    mem_req_addr = '0;
    mem_req_tag  = '0;
    bus_tag      = '0;
    bus_data     = '0;
    for (int i = 0; i < N; i++) begin
      if (send_g[i]) begin
        mem_req_addr = mem_req_addr | ent_addr[i];
        mem_req_tag  = mem_req_tag | TAG_W'(TAG_BASE + i);
      end
      if (hold_g[i]) begin
        bus_data = bus_data | ent_data[i];
        bus_tag  = bus_tag | TAG_W'(TAG_BASE + i);
      end
    end
  end
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int N_ENTRIES = 3,
  parameter int TAG_BASE  = 6,
  parameter int TAG_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [TAG_W-1:0] mem_req_tag,
  input logic             bus_req,
  input logic             bus_grant,
  input logic [TAG_W-1:0] bus_tag
);
  localparam int TAG_LAST = TAG_BASE + N_ENTRIES - 1;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iss_ready && !mem_req_valid && !bus_req));

  assert_req_tag_range_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (int'(mem_req_tag) >= TAG_BASE && int'(mem_req_tag) <= TAG_LAST));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  assert_bus_held_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_grant) |=> bus_req);

  assert_bus_tag_range_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (int'(bus_tag) >= TAG_BASE && int'(bus_tag) <= TAG_LAST));
endmodule

bind load_buffer lb_checker #(
  .N_ENTRIES(N_ENTRIES), .TAG_BASE(TAG_BASE), .TAG_W(TAG_W)
) u_lb_chk (
  .clk(clk), .rst(rst), .iss_ready(iss_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_tag(mem_req_tag), .bus_req(bus_req), .bus_grant(bus_grant),
  .bus_tag(bus_tag)
);

// File: tb/load_buffer_test.sv
`timescale 1ns/1ps
module load_buffer_test;
  localparam int N  = 3;
  localparam int TB = 6;
  localparam int TW = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [AW-1:0] iss_base = '0, iss_offset = '0;
  logic iss_ready;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic bus_req, bus_grant = 1'b0;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_buffer #(.N_ENTRIES(N), .TAG_BASE(TB), .TAG_W(TW), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_base(iss_base),
    .iss_offset(iss_offset), .iss_ready(iss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_rsp_data(mem_rsp_data), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_tag(bus_tag), .bus_data(bus_data)
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  bit            busy [N];
  bit            pend [N];
  bit            got  [N];
  logic [AW-1:0] eaddr[N];

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is still held
    chk(iss_ready && !mem_req_valid && !bus_req, "R1", {iss_ready, mem_req_valid, bus_req}, 3'b100);
    rst = 1'b0;
    tick();
    chk(iss_ready && !mem_req_valid && !bus_req, "R1", {iss_ready, mem_req_valid, bus_req}, 3'b100);

    // R3 timing and address
    iss_valid = 1; iss_base = 16'd100; iss_offset = 16'd4;
    tick();
    iss_valid = 0;
    chk(!mem_req_valid, "R3", mem_req_valid, 0);
    tick();
    chk(mem_req_valid && mem_req_addr == 16'd104, "R3", mem_req_addr, 16'd104);
    chk(mem_req_tag == 4'd6, "R2", mem_req_tag, 6);
    iss_valid = 1; iss_base = 16'd200; iss_offset = 16'd8;
    tick();
    iss_base = 16'd300; iss_offset = 16'd12;
    tick();
    iss_valid = 0;
    chk(!iss_ready, "R9", iss_ready, 0);
    iss_valid = 1; iss_base = 16'h500; iss_offset = 16'h1;
    tick();
    iss_valid = 0;
    chk(mem_req_valid && mem_req_tag == 4'd6, "R4", mem_req_tag, 6);
    mem_req_ready = 1;
    tick();
    chk(mem_req_tag == 4'd7 && mem_req_addr == 16'd208, "R5", {mem_req_tag, mem_req_addr}, {4'd7, 16'd208});
    tick();
    chk(mem_req_tag == 4'd8 && mem_req_addr == 16'd312, "R5", {mem_req_tag, mem_req_addr}, {4'd8, 16'd312});
    tick();
    mem_req_ready = 0;
    chk(!mem_req_valid, "R9", mem_req_valid, 0);

    // R6 responses: unrelated tag, out of order, duplicate
    mem_rsp_valid = 1; mem_rsp_tag = 4'd3; mem_rsp_data = 32'hDEAD_0003;
    tick();
    chk(!bus_req, "R6", bus_req, 0);
    mem_rsp_tag = 4'd8; mem_rsp_data = 32'h1111_0008;
    tick();
    chk(bus_req && bus_tag == 4'd8 && bus_data == 32'h1111_0008, "R7", {bus_tag, bus_data}, {4'd8, 32'h1111_0008});
    mem_rsp_tag = 4'd6; mem_rsp_data = 32'h1111_0006;
    tick();
    chk(bus_tag == 4'd6, "R7", bus_tag, 6);
    mem_rsp_tag = 4'd8; mem_rsp_data = 32'hBAD0_BAD0;
    tick();
    mem_rsp_tag = 4'd7; mem_rsp_data = 32'h1111_0007;
    tick();
    mem_rsp_valid = 0;
    bus_grant = 1;
    chk(bus_tag == 4'd6 && bus_data == 32'h1111_0006, "R7", {bus_tag, bus_data}, {4'd6, 32'h1111_0006});
    tick();
    chk(bus_tag == 4'd7 && bus_data == 32'h1111_0007, "R6", {bus_tag, bus_data}, {4'd7, 32'h1111_0007});
    tick();
    chk(bus_tag == 4'd8 && bus_data == 32'h1111_0008, "R6", {bus_tag, bus_data}, {4'd8, 32'h1111_0008});
    tick();
    bus_grant = 0;
    chk(!bus_req && iss_ready, "R8", {bus_req, iss_ready}, 2'b01);

    // random phase
    for (int i = 0; i < N; i++) begin
      busy[i] = 0; pend[i] = 0; got[i] = 0; eaddr[i] = '0;
    end
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int nfree;
      int gt;
      bit do_issue;
      nfree = 0;
      gt = -1;
      do_issue = (cyc < 3700);
      for (int i = 0; i < N; i++) if (!busy[i]) nfree++;
      chk(iss_ready == (nfree > 0), "R8", iss_ready, nfree > 0);

      mem_rsp_valid = 0;
      if ($urandom % 3 == 0) begin
        int st;
        st = $urandom % N;
        for (int k = 0; k < N; k++) begin
          int ix;
          ix = (st + k) % N;
          if (pend[ix] && !mem_rsp_valid) begin
            mem_rsp_valid = 1; mem_rsp_tag = TW'(TB + ix); mem_rsp_data = memf(eaddr[ix]);
            pend[ix] = 0; got[ix] = 1;
          end
        end
      end else if ($urandom % 5 == 0) begin
        int ix;
        ix = $urandom % N;
        if (!pend[ix]) begin
          mem_rsp_valid = 1; mem_rsp_tag = TW'(TB + ix); mem_rsp_data = $urandom;
        end else begin
          mem_rsp_valid = 1; mem_rsp_tag = TW'($urandom % TB); mem_rsp_data = $urandom;
        end
      end

      mem_req_ready = ($urandom % 2 == 0);
      if (mem_req_valid) begin
        int t;
        t = int'(mem_req_tag) - TB;
        if (t >= 0 && t < N) begin
          chk(busy[t] && !pend[t] && !got[t] && mem_req_addr == eaddr[t], "R3", mem_req_addr, eaddr[t]);
          if (mem_req_ready) pend[t] = 1;
        end else chk(0, "R2", mem_req_tag, TB);
      end

      bus_grant = 0;
      if (bus_req) begin
        int t;
        t = int'(bus_tag) - TB;
        if (t >= 0 && t < N) begin
          chk(got[t] && bus_data == memf(eaddr[t]), "R7", bus_data, memf(eaddr[t]));
          if ($urandom % 2 == 0) begin
            bus_grant = 1; gt = t;
          end
        end else chk(0, "R7", bus_tag, TB);
      end

      iss_valid = 0;
      if (do_issue && iss_ready && nfree > 0 && ($urandom % 2 == 0)) begin
        int ix;
        ix = -1;
        for (int i = N - 1; i >= 0; i--) if (!busy[i]) ix = i;
        iss_valid = 1;
        iss_base = AW'($urandom);
        iss_offset = AW'($urandom);
        busy[ix] = 1;
        eaddr[ix] = iss_base + iss_offset;
      end

      if (gt >= 0) begin
        busy[gt] = 0; got[gt] = 0;
      end
      tick();
    end
    iss_valid = 0; mem_rsp_valid = 0; bus_grant = 0; mem_req_ready = 0;
    chk(iss_ready && !bus_req && !mem_req_valid, "R8", {iss_ready, bus_req, mem_req_valid}, 3'b100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule